// File: doc/BRIEF.md
# GPIO interrupt unit

This block turns the conditioned input level of each GPIO line into an interrupt request. Every line has a detector, a sticky status flag and an enable flag. The input has already been filtered and corrected for polarity, so the detector only ever looks for a rising edge or a high level. Falling-edge or active-low sensing is obtained upstream by inverting the pin. Two configuration inputs per line switch detection on and choose between edge and level sensing.

Software reaches each line through one small register word. The word sits at byte offset `REG_BASE + 8*n` for line n. Writing a 1 to one bit of the word acknowledges the status flag. Writing a 1 to another bit sets the status flag, which lets software raise an interrupt by itself. Two further bits set and clear the enable, so a single write can mask and acknowledge at once.

Reading the word returns the status and the enable. The read port also computes the message vector index of the addressed line, which is `vec_base + 2*n`. A line's request output is high while its status, its enable and its detection switch are all set.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset is asserted, every status flag and every enable flag is 0, all `irq` bits are 0, and every read returns 0.
- R2: In edge mode (`cfg_edge_mode[n]`=1, `cfg_det_en[n]`=1), a rising edge of `line_level[n]` sets status on the following clock edge. A level that stays high does not set status again after an acknowledge.
- R3: In level mode (`cfg_edge_mode[n]`=0, `cfg_det_en[n]`=1), status is set on every clock edge at which the level is high. An acknowledge therefore does not clear it while the level stays high. Once the level is low, status stays set until it is acknowledged.
- R4: While `cfg_det_en[n]`=0, the input level never sets status and `irq[n]` stays 0.
- R5: A write with data bit 0 = 1 clears status (acknowledge). A write with data bit 1 = 1 sets status, whatever the detector state is.
- R6: A write with data bit 3 = 1 sets the enable, and a write with bit 2 = 1 clears it. If both bits are 1, set wins. Data 4'b0101 clears the enable and the status in one write.
- R7: When a detection event and an acknowledge fall on the same clock edge, status ends up 1.
- R8: `irq[n]` is 1 exactly when status, enable and `cfg_det_en[n]` are all 1 for line n. Other lines do not affect it.
- R9: A word is selected only by an address equal to `REG_BASE + 8*n` with n < `NUM_LINES`. Writes to any other address change no line, and reads of any other address return 0.
- R10: Read data carries status in bit 0 and enable in bit 3. Bits 1 and 2 read as 0.
- R11: For a selected read address, `rd_vector` equals `vec_base + 2*n`. For an address that selects no line, it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_level | input | NUM_LINES | Filtered, polarity-corrected level of each line |
| cfg_det_en | input | NUM_LINES | Per-line detection switch |
| cfg_edge_mode | input | NUM_LINES | Per-line sensing mode: 1 edge, 0 level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the written word |
| wr_data | input | 4 | Write data: bit0 ack, bit1 status set, bit2 enable clear, bit3 enable set |
| rd_addr | input | ADDR_W | Byte address of the read word |
| vec_base | input | VEC_W | Base index of the message vector range |
| rd_data | output | 4 | Read data: bit0 status, bit3 enable |
| rd_vector | output | VEC_W | Vector index of the addressed line |
| irq | output | NUM_LINES | Per-line interrupt request |

## Verification
The two functions that can meet on one clock edge are the detector setting status and a register write that acknowledges it. The bench creates this collision in both sensing modes. In edge mode it raises the input level in the same cycle as an acknowledge write. In level mode it issues an acknowledge while the level is held high. In both cases the flag must read back as 1 on the next cycle. A second collision inside the register word, a write that both sets and clears the enable, is also driven, and the enable must read back as set.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Width of one line's register word.
    localparam int REG_W        = 4;

    // Write-strobe bit positions. Software relies on this layout.
    localparam int ACK_BIT      = 0;
    localparam int STAT_SET_BIT = 1;
    localparam int ENA_CLR_BIT  = 2;
    localparam int ENA_SET_BIT  = 3;

    // log2 of the byte stride between the words of two lines.
    localparam int STRIDE_LOG2  = 3;

    typedef struct packed {
        logic ack;
        logic stat_set;
        logic ena_clr;
        logic ena_set;
    } line_wr_t;

    typedef struct packed {
        logic prev;
        logic stat;
        logic ena;
    } cell_state_t;

endpackage

// File: rtl/gpio_irq_addr_dec.sv
module gpio_irq_addr_dec
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 12,
    parameter int REG_BASE  = 'h800,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] slot;

    always_comb begin
        offset = addr - ADDR_W'(REG_BASE);
        slot   = offset >> STRIDE_LOG2;
        hit    = (addr >= ADDR_W'(REG_BASE))
              && (offset[STRIDE_LOG2-1:0] == '0)
              && (slot < ADDR_W'(NUM_LINES));
        idx    = slot[IDX_W-1:0];
    end

endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     level,
    input  logic     det_en,
    input  logic     det_edge,
    input  line_wr_t wr,
    output logic     stat,
    output logic     ena,
    output logic     irq
);

    cell_state_t s_d, s_q;
    logic        event_d;

    always_comb begin
        s_d      = s_q;
        s_d.prev = level;
        event_d  = det_en && level && (!det_edge || !s_q.prev);

        // A detection event or a software set beats an acknowledge.
        if (event_d || wr.stat_set) begin
            s_d.stat = 1'b1;
        end else if (wr.ack) begin
            s_d.stat = 1'b0;
        end

        if (wr.ena_set) begin
            s_d.ena = 1'b1;
        end else if (wr.ena_clr) begin
            s_d.ena = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat = s_q.stat;
    assign ena  = s_q.ena;
    assign irq  = s_q.stat & s_q.ena & det_en;

endmodule

// File: rtl/gpio_irq_rdport.sv
module gpio_irq_rdport
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int VEC_W     = 8,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 hit,
    input  logic [IDX_W-1:0]     idx,
    input  logic [NUM_LINES-1:0] stat_vec,
    input  logic [NUM_LINES-1:0] ena_vec,
    input  logic [VEC_W-1:0]     vec_base,
    output logic [REG_W-1:0]     rd_data,
    output logic [VEC_W-1:0]     rd_vector
);

    always_comb begin
        rd_data   = '0;
        rd_vector = '0;
        if (hit) begin
            rd_data[ACK_BIT]     = stat_vec[idx];
            rd_data[ENA_SET_BIT] = ena_vec[idx];
            rd_vector            = vec_base + VEC_W'({idx, 1'b0});
        end
    end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 12,
    parameter int REG_BASE  = 'h800,
    parameter int VEC_W     = 8,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_level,
    input  logic [NUM_LINES-1:0] cfg_det_en,
    input  logic [NUM_LINES-1:0] cfg_edge_mode,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [VEC_W-1:0]     vec_base,
    output logic [REG_W-1:0]     rd_data,
    output logic [VEC_W-1:0]     rd_vector,
    output logic [NUM_LINES-1:0] irq
);

    logic                 wr_hit, rd_hit;
    logic [IDX_W-1:0]     wr_idx, rd_idx;
    logic [NUM_LINES-1:0] stat_vec, ena_vec;

    gpio_irq_addr_dec #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .REG_BASE  (REG_BASE)
    ) u_wr_dec (
        .addr (wr_addr),
        .hit  (wr_hit),
        .idx  (wr_idx)
    );

    gpio_irq_addr_dec #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .REG_BASE  (REG_BASE)
    ) u_rd_dec (
        .addr (rd_addr),
        .hit  (rd_hit),
        .idx  (rd_idx)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        line_wr_t wr_line;
        logic     sel;

        always_comb begin
            sel              = wr_en && wr_hit && (wr_idx == IDX_W'(n));
            wr_line.ack      = sel && wr_data[ACK_BIT];
            wr_line.stat_set = sel && wr_data[STAT_SET_BIT];
            wr_line.ena_clr  = sel && wr_data[ENA_CLR_BIT];
            wr_line.ena_set  = sel && wr_data[ENA_SET_BIT];
        end

        gpio_irq_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .level    (line_level[n]),
            .det_en   (cfg_det_en[n]),
            .det_edge (cfg_edge_mode[n]),
            .wr       (wr_line),
            .stat     (stat_vec[n]),
            .ena      (ena_vec[n]),
            .irq      (irq[n])
        );
    end

    gpio_irq_rdport #(
        .NUM_LINES (NUM_LINES),
        .VEC_W     (VEC_W)
    ) u_rdport (
        .hit       (rd_hit),
        .idx       (rd_idx),
        .stat_vec  (stat_vec),
        .ena_vec   (ena_vec),
        .vec_base  (vec_base),
        .rd_data   (rd_data),
        .rd_vector (rd_vector)
    );

endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
    parameter int NUM_LINES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] line_level,
    input logic [NUM_LINES-1:0] cfg_det_en,
    input logic [NUM_LINES-1:0] cfg_edge_mode,
    input logic                 wr_en,
    input logic                 wr_ack,
    input logic                 wr_set,
    input logic [NUM_LINES-1:0] stat_vec,
    input logic [NUM_LINES-1:0] ena_vec
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stat_vec == '0 && ena_vec == '0));

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_chk
        // R2
        edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_det_en[n] && cfg_edge_mode[n] && line_level[n] && !$past(line_level[n]))
            |=> stat_vec[n]);

        // R3
        level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_det_en[n] && !cfg_edge_mode[n] && line_level[n]) |=> stat_vec[n]);

        // R4
        det_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_det_en[n] && !(wr_en && wr_set)) |=> !$rose(stat_vec[n]));

        // R5
        ack_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(stat_vec[n]) |-> $past(wr_en && wr_ack));

        // R6
        ena_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(ena_vec[n]) || $fell(ena_vec[n])) |-> $past(wr_en));
    end

endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_level    (line_level),
    .cfg_det_en    (cfg_det_en),
    .cfg_edge_mode (cfg_edge_mode),
    .wr_en         (wr_en),
    .wr_ack        (wr_data[0]),
    .wr_set        (wr_data[1]),
    .stat_vec      (stat_vec),
    .ena_vec       (ena_vec)
);

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;

    localparam int NL = 8;
    localparam int AW = 12;
    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NL-1:0] line_level, cfg_det_en, cfg_edge_mode;
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [3:0]    wr_data, rd_data;
    logic [VW-1:0] vec_base, rd_vector;
    logic [NL-1:0] irq;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_unit #(.NUM_LINES(NL), .ADDR_W(AW), .REG_BASE('h800), .VEC_W(VW)) u_gpio_irq_unit (
        .clk (clk), .rst_n (rst_n), .line_level (line_level), .cfg_det_en (cfg_det_en),
        .cfg_edge_mode (cfg_edge_mode), .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_addr (rd_addr), .vec_base (vec_base), .rd_data (rd_data), .rd_vector (rd_vector),
        .irq (irq)
    );

    typedef struct packed {
        logic       we;
        logic [3:0] wd;
        logic       lvl;
        logic       en;
        logic       edg;
        logic [3:0] exp_rd;
        logic       exp_irq;
    } vec_t;

    // Sequence on line 2 (word at 0x810); expected values are after the edge.
    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 4'h0, 1'b0},  // R4 idle, nothing set
        '{1'b1, 4'h8, 1'b0, 1'b1, 1'b1, 4'h8, 1'b0},  // R6 enable set
        '{1'b0, 4'h0, 1'b1, 1'b1, 1'b1, 4'h9, 1'b1},  // R2 rising edge
        '{1'b1, 4'h1, 1'b1, 1'b1, 1'b1, 4'h8, 1'b0},  // R5 ack, level held
        '{1'b0, 4'h0, 1'b1, 1'b1, 1'b1, 4'h8, 1'b0},  // R2 held high, no re-set
        '{1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 4'h8, 1'b0},  // R2 level drops
        '{1'b1, 4'h1, 1'b1, 1'b1, 1'b1, 4'h9, 1'b1},  // R7 edge with ack
        '{1'b1, 4'h1, 1'b1, 1'b1, 1'b0, 4'h9, 1'b1},  // R3 level high beats ack
        '{1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'h9, 1'b1},  // R3 sticky after level low
        '{1'b1, 4'h1, 1'b0, 1'b1, 1'b0, 4'h8, 1'b0},  // R3 ack once low
        '{1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 4'h8, 1'b0},  // R4 detection off
        '{1'b1, 4'h2, 1'b1, 1'b0, 1'b0, 4'h9, 1'b0},  // R5 software set
        '{1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'h9, 1'b1},  // R8 all three set
        '{1'b1, 4'h4, 1'b0, 1'b1, 1'b0, 4'h1, 1'b0},  // R6 enable clear
        '{1'b1, 4'hC, 1'b0, 1'b1, 1'b0, 4'h9, 1'b1},  // R6 set beats clear
        '{1'b1, 4'h5, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0}   // R6 mask and ack
    };
    localparam string TAGS [NV] = '{"R4", "R6", "R2", "R5", "R2", "R2", "R7", "R3",
                                    "R3", "R3", "R4", "R5", "R8", "R6", "R6", "R6"};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [AW-1:0] a, input logic [3:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [AW-1:0] a, input logic [3:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; line_level = '0; cfg_det_en = '0; cfg_edge_mode = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = 12'h800; vec_base = 8'h30;
        repeat (3) @(negedge clk);
        check("R1", irq, 0);
        read_check("R1", 12'h800, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", irq, 0);

        // Table walk on line 2
        for (int i = 0; i < NV; i++) begin
            rd_addr          = 12'h810;
            line_level[2]    = VEC[i].lvl;
            cfg_det_en[2]    = VEC[i].en;
            cfg_edge_mode[2] = VEC[i].edg;
            wr_addr          = 12'h810;
            wr_data          = VEC[i].wd;
            wr_en            = VEC[i].we;
            @(negedge clk);
            wr_en = 1'b0;
            check(TAGS[i], rd_data, VEC[i].exp_rd);
            check(TAGS[i], irq[2], VEC[i].exp_irq);
        end

        // R9 misaligned, out-of-range and below-base writes are ignored
        reg_write(12'h812, 4'hA);
        reg_write(12'h840, 4'hA);
        reg_write(12'h7F8, 4'hA);
        read_check("R9", 12'h810, 4'h0);
        read_check("R9", 12'h812, 4'h0);
        read_check("R9", 12'h838, 4'h0);
        read_check("R9", 12'h800, 4'h0);
        check("R9", irq, 0);
        reg_write(12'h838, 4'h8);
        read_check("R9", 12'h838, 4'h8);
        read_check("R10", 12'h830, 4'h0);

        // R11 vector index
        rd_addr = 12'h828; #1; check("R11", rd_vector, 8'h3A);
        rd_addr = 12'h800; #1; check("R11", rd_vector, 8'h30);
        rd_addr = 12'h838; #1; check("R11", rd_vector, 8'h3E);
        rd_addr = 12'h844; #1; check("R11", rd_vector, 8'h00);

        // R8 line 0 edge, other lines quiet
        @(negedge clk);
        reg_write(12'h800, 4'h8);
        cfg_det_en[0] = 1'b1; cfg_edge_mode[0] = 1'b1; line_level[0] = 1'b1;
        @(negedge clk);
        check("R8", irq, 8'h01);
        read_check("R10", 12'h800, 4'h9);

        // R1 reset in the middle of operation
        cfg_det_en = '0; line_level = '0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", irq, 0);
        read_check("R1", 12'h800, 4'h0);
        read_check("R1", 12'h838, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        read_check("R1", 12'h800, 4'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule